// File: doc/BRIEF.md
# Scaler Phase Increment Calculator

This block prepares the stepping parameters that a polyphase video scaler needs before a frame starts. From the luma sizes of the source and destination images, the source and destination sampling formats and a code that tells where the chroma samples sit relative to luma, it works out the chroma image sizes. It then produces four phase increments: vertical luma, vertical chroma, horizontal luma and horizontal chroma. Each increment is the ratio of source size to destination size with 13 fractional bits, rounded to nearest.

It also produces the two chroma start phases. When the source is 4:2:0, these are moved back by a quarter or a half of a chroma sample, so that chroma lines up with the first luma line and column. A single start pulse latches all inputs. One shared restoring divider then computes the four increments in turn. When the results are ready, a one-cycle done strobe is raised. The results stay on parallel output registers until the next start.

Top module: `scale_step_calc`

## Requirements
- R1: After reset, busy, done and err are low, and all four increments and both start phases read zero.
- R2: Each increment equals floor(((src << 13) + floor(dst / 2)) / dst). That is the ratio with 13 fractional bits, rounded to nearest. The pairs are (source height, destination height), (chroma source height, chroma destination height), (source width, destination width) and (chroma source width, chroma destination width).
- R3: Format codes are 0 = 4:2:0, 1 = 4:2:2, and 2 = 4:4:4 or RGB; code 3 acts as 2. Chroma source width is halved (floor) for codes 0 and 1. Chroma source height is halved only for code 0. Chroma destination width is halved only when the destination code is 1. Chroma destination height always equals luma destination height.
- R4: For a 4:2:0 source, the vertical chroma start phase is -2048 for location codes 0 and 1, -4096 for codes 4 and 5, and 0 for any other code. Both start phases are 32-bit two's complement.
- R5: For a 4:2:0 source, the horizontal chroma start phase is -2048 for location codes 1, 3 and 5, and 0 for any other code.
- R6: For a source that is not 4:2:0, both chroma start phases are 0 whatever the location code.
- R7: A start pulse seen while idle latches the inputs and raises busy in the next cycle. Completion is marked by a one-cycle done pulse with busy low. The results then hold their values while inputs change, until the next accepted start.
- R8: A start pulse seen while busy is ignored, and the running computation completes with the values latched at its own start.
- R9: If any of the four divisors (including a halved chroma width) is zero, done comes with err high and all four increments read zero. The next run without a zero divisor clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| srcW | input | DIM_W | Source luma width |
| srcH | input | DIM_W | Source luma height |
| dstW | input | DIM_W | Destination luma width |
| dstH | input | DIM_W | Destination luma height |
| srcFmt | input | 2 | Source sampling format code |
| dstFmt | input | 2 | Destination sampling format code |
| chromaLoc | input | 3 | Chroma siting code 0..5 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Zero divisor seen in the last run |
| vLumInc | output | DIM_W+FRAC | Vertical luma increment |
| vChrInc | output | DIM_W+FRAC | Vertical chroma increment |
| hLumInc | output | DIM_W+FRAC | Horizontal luma increment |
| hChrInc | output | DIM_W+FRAC | Horizontal chroma increment |
| cVStart | output | 32 | Vertical chroma start phase, signed |
| cHStart | output | 32 | Horizontal chroma start phase, signed |

## Verification
Each increment has its own divisor and its own result slot. A wrong operand index or a slip in the divider's iteration count therefore shows up as a wrong value in one named increment when done is raised, and that happens within a single run. A latch taken on a start during busy would also show up at that same done: results would follow the ignored inputs. A sequencer that never returns to idle shows up as a missing done strobe. The start phases are fixed at capture, so a wrong siting decode is visible at the first done for each location code.

// File: rtl/scale_step_pkg.sv
package scale_step_pkg;

  localparam logic [1:0] FMT420 = 2'd0;
  localparam logic [1:0] FMT422 = 2'd1;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic       capture;  // latch inputs, clear results
    logic       loadOp;   // load dividend/divisor of operand idx
    logic       step;     // one restoring-division iteration
    logic       store;    // write quotient into result idx
    logic       fin;      // raise done (and err if zero divisor)
    logic [1:0] idx;      // operand index 0..3
  } stepStrobe_t;

endpackage

// File: rtl/sstep_ctrl.sv
module sstep_ctrl
  import scale_step_pkg::*;
#(
  parameter int NW = 26
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        zeroDiv,
  output stepStrobe_t stb,
  output logic        busy
);
  localparam int CW = $clog2(NW + 1);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_LOAD, S_RUN, S_STORE} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [1:0]      idx;

  always_comb begin
    stb         = '0;
    stb.idx     = idx;
    case (state)
      S_IDLE:  stb.capture = start;
      S_CHECK: stb.fin     = zeroDiv;
      S_LOAD:  stb.loadOp  = 1'b1;
      S_RUN:   stb.step    = 1'b1;
      S_STORE: begin
        stb.store = 1'b1;
        stb.fin   = (idx == 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_CHECK;
          idx   <= '0;
        end
        S_CHECK: state <= zeroDiv ? S_IDLE : S_LOAD;
        S_LOAD: begin
          cnt   <= '0;
          state <= S_RUN;
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NW - 1)) state <= S_STORE;
        end
        S_STORE: begin
          if (idx == 2'd3) state <= S_IDLE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/sstep_dp.sv
module sstep_dp
  import scale_step_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int FRAC  = 13,
  localparam int QW   = DIM_W + FRAC,
  localparam int NW   = QW + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  stepStrobe_t        stb,
  input  logic [DIM_W-1:0]   srcW,
  input  logic [DIM_W-1:0]   srcH,
  input  logic [DIM_W-1:0]   dstW,
  input  logic [DIM_W-1:0]   dstH,
  input  logic [1:0]         srcFmt,
  input  logic [1:0]         dstFmt,
  input  logic [2:0]         chromaLoc,
  output logic               zeroDiv,
  output logic [QW-1:0]      incOut [4],
  output logic signed [31:0] cVStart,
  output logic signed [31:0] cHStart,
  output logic               done,
  output logic               err
);
  localparam logic signed [31:0] QUARTER = 32'sd1 <<< (FRAC - 2);
  localparam logic signed [31:0] HALF    = 32'sd1 <<< (FRAC - 1);

  logic [DIM_W-1:0] numR [4];
  logic [DIM_W-1:0] denR [4];
  logic [DIM_W-1:0] divisor;
  logic [DIM_W-1:0] rem;
  logic [NW-1:0]    quo;
  logic [DIM_W:0]   trial;
  logic             srcSub;

  assign srcSub = (srcFmt == FMT420) || (srcFmt == FMT422);

  always_comb begin
    zeroDiv = 1'b0;
    for (int k = 0; k < 4; k++) zeroDiv = zeroDiv | (denR[k] == '0);
  end

  assign trial = {rem, quo[NW-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 4; k++) begin
        numR[k]   <= '0;
        denR[k]   <= '0;
        incOut[k] <= '0;
      end
      divisor <= '0;
      rem     <= '0;
      quo     <= '0;
      cVStart <= '0;
      cHStart <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stb.capture) begin
        numR[0] <= srcH;
        denR[0] <= dstH;
        numR[1] <= (srcFmt == FMT420) ? (srcH >> 1) : srcH;
        denR[1] <= dstH;
        numR[2] <= srcW;
        denR[2] <= dstW;
        numR[3] <= srcSub ? (srcW >> 1) : srcW;
        denR[3] <= (dstFmt == FMT422) ? (dstW >> 1) : dstW;
        for (int k = 0; k < 4; k++) incOut[k] <= '0;
        if (srcFmt == FMT420) begin
          case (chromaLoc)
            3'd0, 3'd1: cVStart <= -QUARTER;
            3'd4, 3'd5: cVStart <= -HALF;
            default:    cVStart <= '0;
          endcase
          cHStart <= (chromaLoc == 3'd1 || chromaLoc == 3'd3 || chromaLoc == 3'd5)
                     ? -QUARTER : 32'sd0;
        end else begin
          cVStart <= '0;
          cHStart <= '0;
        end
      end
      if (stb.loadOp) begin
        quo     <= {1'b0, numR[stb.idx], {FRAC{1'b0}}} + NW'(denR[stb.idx] >> 1);
        divisor <= denR[stb.idx];
        rem     <= '0;
      end
      if (stb.step) begin
        if (trial >= {1'b0, divisor}) begin
          rem <= DIM_W'(trial - {1'b0, divisor});
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          rem <= trial[DIM_W-1:0];
          quo <= {quo[NW-2:0], 1'b0};
        end
      end
      if (stb.store) incOut[stb.idx] <= quo[QW-1:0];
      if (stb.fin) begin
        done <= 1'b1;
        err  <= zeroDiv;
      end
    end
  end

endmodule

// File: rtl/scale_step_calc.sv
module scale_step_calc
  import scale_step_pkg::*;
#(
  parameter int DIM_W = 12,
  parameter int FRAC  = 13,
  localparam int QW   = DIM_W + FRAC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [DIM_W-1:0]   srcW,
  input  logic [DIM_W-1:0]   srcH,
  input  logic [DIM_W-1:0]   dstW,
  input  logic [DIM_W-1:0]   dstH,
  input  logic [1:0]         srcFmt,
  input  logic [1:0]         dstFmt,
  input  logic [2:0]         chromaLoc,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [QW-1:0]      vLumInc,
  output logic [QW-1:0]      vChrInc,
  output logic [QW-1:0]      hLumInc,
  output logic [QW-1:0]      hChrInc,
  output logic signed [31:0] cVStart,
  output logic signed [31:0] cHStart
);
  stepStrobe_t stb;
  logic        zeroDiv;
  logic [QW-1:0] incOut [4];

  sstep_ctrl #(.NW(QW + 1)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .zeroDiv(zeroDiv),
    .stb(stb), .busy(busy)
  );

  sstep_dp #(.DIM_W(DIM_W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .srcW(srcW), .srcH(srcH), .dstW(dstW), .dstH(dstH),
    .srcFmt(srcFmt), .dstFmt(dstFmt), .chromaLoc(chromaLoc),
    .zeroDiv(zeroDiv), .incOut(incOut),
    .cVStart(cVStart), .cHStart(cHStart), .done(done), .err(err)
  );

  assign vLumInc = incOut[0];
  assign vChrInc = incOut[1];
  assign hLumInc = incOut[2];
  assign hChrInc = incOut[3];

endmodule

// File: rtl/sstep_chk.sv
module sstep_chk #(
  parameter int DIM_W = 12,
  parameter int FRAC  = 13,
  localparam int QW   = DIM_W + FRAC
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic [QW-1:0]      vLumInc,
  input logic [QW-1:0]      vChrInc,
  input logic [QW-1:0]      hLumInc,
  input logic [QW-1:0]      hChrInc,
  input logic signed [31:0] cVStart,
  input logic signed [31:0] cHStart
);
  localparam logic signed [31:0] QTR = 32'sd1 <<< (FRAC - 2);
  localparam logic signed [31:0] HLF = 32'sd1 <<< (FRAC - 1);

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R7: done only when not busy
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R7: the end of a run is always marked by done
  a_r7_fall_done: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);
  // R9: error run leaves increments at zero
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> (vLumInc == '0 && vChrInc == '0 && hLumInc == '0 && hChrInc == '0));
  // R4: vertical start is one of three legal phases
  a_r4_vstart_set: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cVStart == 32'sd0 || cVStart == -QTR || cVStart == -HLF));
  // R5: horizontal start is one of two legal phases
  a_r5_hstart_set: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cHStart == 32'sd0 || cHStart == -QTR));
endmodule

bind scale_step_calc sstep_chk #(.DIM_W(DIM_W), .FRAC(FRAC)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err),
  .vLumInc(vLumInc), .vChrInc(vChrInc), .hLumInc(hLumInc), .hChrInc(hChrInc),
  .cVStart(cVStart), .cHStart(cHStart)
);

// File: tb/test_scale_step_calc.sv
module test_scale_step_calc;
  localparam int CLK_PERIOD = 10;
  localparam int DIM_W = 12;
  localparam int FRAC  = 13;
  localparam int QW    = DIM_W + FRAC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [DIM_W-1:0] srcW = '0, srcH = '0, dstW = '0, dstH = '0;
  logic [1:0] srcFmt = '0, dstFmt = '0;
  logic [2:0] chromaLoc = '0;
  logic busy, done, err;
  logic [QW-1:0] vLumInc, vChrInc, hLumInc, hChrInc;
  logic signed [31:0] cVStart, cHStart;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scale_step_calc #(.DIM_W(DIM_W), .FRAC(FRAC)) i_scale_step_calc (
    .clk(clk), .rstN(rstN), .start(start),
    .srcW(srcW), .srcH(srcH), .dstW(dstW), .dstH(dstH),
    .srcFmt(srcFmt), .dstFmt(dstFmt), .chromaLoc(chromaLoc),
    .busy(busy), .done(done), .err(err),
    .vLumInc(vLumInc), .vChrInc(vChrInc), .hLumInc(hLumInc), .hChrInc(hChrInc),
    .cVStart(cVStart), .cHStart(cHStart)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint incExp(int s, int d);
    if (d == 0) return 0;
    return ((longint'(s) <<< 13) + longint'(d / 2)) / longint'(d);
  endfunction

  // expected values of the last applied configuration
  longint eV, eVC, eH, eHC, eVS, eHS;
  int eErr;

  task automatic computeExp(int sw, int sh, int dw, int dh, int sf, int df, int loc);
    int scw, sch, dcw;
    scw = (sf == 0 || sf == 1) ? sw / 2 : sw;
    sch = (sf == 0) ? sh / 2 : sh;
    dcw = (df == 1) ? dw / 2 : dw;
    eErr = (dh == 0 || dw == 0 || dcw == 0) ? 1 : 0;
    eV  = eErr ? 0 : incExp(sh, dh);
    eVC = eErr ? 0 : incExp(sch, dh);
    eH  = eErr ? 0 : incExp(sw, dw);
    eHC = eErr ? 0 : incExp(scw, dcw);
    eVS = 0;
    eHS = 0;
    if (sf == 0) begin
      if (loc == 0 || loc == 1) eVS = -2048;
      if (loc == 4 || loc == 5) eVS = -4096;
      if (loc == 1 || loc == 3 || loc == 5) eHS = -2048;
    end
  endtask

  task automatic applyIn(int sw, int sh, int dw, int dh, int sf, int df, int loc);
    srcW = DIM_W'(sw); srcH = DIM_W'(sh); dstW = DIM_W'(dw); dstH = DIM_W'(dh);
    srcFmt = 2'(sf); dstFmt = 2'(df); chromaLoc = 3'(loc);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkOuts(string req);
    chk("R7", {req, " done"}, longint'(done), 1);
    chk("R7", {req, " busy"}, longint'(busy), 0);
    chk("R9", {req, " err"}, longint'(err), eErr);
    chk(req, "vLumInc", longint'(vLumInc), eV);
    chk(req, "vChrInc", longint'(vChrInc), eVC);
    chk(req, "hLumInc", longint'(hLumInc), eH);
    chk(req, "hChrInc", longint'(hChrInc), eHC);
    chk(req, "cVStart", longint'(cVStart), eVS);
    chk(req, "cHStart", longint'(cHStart), eHS);
    @(negedge clk);
    chk("R7", {req, " done one cycle"}, longint'(done), 0);
  endtask

  task automatic runCase(string req, int sw, int sh, int dw, int dh, int sf, int df, int loc);
    applyIn(sw, sh, dw, dh, sf, df, loc);
    computeExp(sw, sh, dw, dh, sf, df, loc);
    pulseStart();
    chk("R7", {req, " busy after start"}, longint'(busy), 1);
    waitDone();
    checkOuts(req);
  endtask

  task automatic testReset();
    chk("R1", "busy", longint'(busy), 0);
    chk("R1", "done", longint'(done), 0);
    chk("R1", "err", longint'(err), 0);
    chk("R1", "vLumInc", longint'(vLumInc), 0);
    chk("R1", "hChrInc", longint'(hChrInc), 0);
    chk("R1", "cVStart", longint'(cVStart), 0);
    chk("R1", "cHStart", longint'(cHStart), 0);
  endtask

  task automatic testRgb();
    runCase("R2", 1920, 1080, 1280, 720, 2, 2, 0);
    runCase("R2", 640, 480, 1920, 1080, 2, 2, 1);
    runCase("R2", 1000, 1000, 1000, 1000, 2, 2, 5);
    runCase("R2", 4095, 3, 1, 7, 3, 2, 0);
  endtask

  task automatic test420Siting();
    for (int loc = 0; loc < 8; loc++) begin
      runCase("R4", 1280, 720, 1920, 1080, 0, 2, loc);
      chk("R5", "h start again", longint'(cHStart), eHS);
    end
  endtask

  task automatic test422();
    runCase("R3", 1279, 719, 800, 600, 1, 1, 0);
    runCase("R6", 720, 480, 1920, 1080, 1, 2, 1);
    runCase("R6", 720, 480, 1920, 1080, 2, 1, 5);
    runCase("R3", 1921, 1081, 333, 77, 0, 1, 4);
  endtask

  task automatic testZeroDst();
    runCase("R9", 100, 100, 0, 50, 2, 2, 0);
    runCase("R9", 100, 100, 1, 50, 0, 1, 0);
    runCase("R9", 100, 100, 50, 0, 0, 2, 1);
    runCase("R9", 300, 200, 150, 100, 2, 2, 0);
  endtask

  task automatic testBusyStart();
    applyIn(1920, 1080, 640, 360, 0, 2, 5);
    computeExp(1920, 1080, 640, 360, 0, 2, 5);
    pulseStart();
    repeat (12) @(negedge clk);
    applyIn(77, 55, 33, 11, 2, 1, 2);
    pulseStart();
    applyIn(9, 9, 9, 9, 1, 2, 3);
    waitDone();
    checkOuts("R8");
  endtask

  task automatic testHold();
    runCase("R7", 800, 600, 1024, 768, 0, 2, 1);
    applyIn(3, 5, 7, 11, 2, 1, 4);
    repeat (6) @(negedge clk);
    chk("R7", "hold vLumInc", longint'(vLumInc), eV);
    chk("R7", "hold hChrInc", longint'(hChrInc), eHC);
    chk("R7", "hold cVStart", longint'(cVStart), eVS);
    chk("R7", "hold busy", longint'(busy), 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testRgb();
    test420Siting();
    test422();
    testZeroDst();
    testBusyStart();
    testHold();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule